// File: doc/BRIEF.md
# In-Order Retirement Queue

This block tracks every decoded instruction of an out-of-order core from allocation to retirement. Instructions enter a circular queue in program order, one per cycle, and each receives a slot index. Execution later reports completion against that index. Each cycle the queue scans a window of up to W slots starting at the oldest entry. It retires the leading run of completed entries and stops at the first one that has not finished.

A retiring entry hands back the physical register that its destination used to map to, so the free list can reuse it. Stores are released to memory as they retire, and a retirement alias table records the committed architectural-to-physical mapping. A completion can flag its instruction as faulting or mispredicted, and an interrupt flags the oldest surviving entry. When a flagged entry retires, the queue empties itself on the next clock edge. It raises a one-cycle recovery pulse, and during that pulse the retirement alias table is the mapping to copy back into the rename table.

Top module: `retire_buf`

## Requirements
- R1: After reset the queue is empty, alloc_ready_o is 1, alloc_idx_o is 0, commit_cnt_o is 0, flush_o is 0 and the retirement table maps architectural register a to physical register a.
- R2: An allocation is written at slot alloc_idx_o and the tail then advances by one, wrapping modulo DEPTH. With DEPTH entries held, alloc_ready_o is 0 and an offered allocation is ignored, so alloc_idx_o does not move.
- R3: A completion (done_valid_i with done_idx_i) marks that slot ready, and retirement sees it from the next cycle. A completion aimed at an empty slot is ignored.
- R4: Each cycle up to W slots are examined from the head, and the leading run of ready entries retires. commit_cnt_o gives the length of that run, and retirement output slot k carries the k-th retiring entry.
- R5: free_valid_o[k] is 1 only for a retiring entry that has a register destination, and free_preg_o[k*PR_W +: PR_W] then holds that entry's previous physical id. An entry without a destination frees nothing.
- R6: store_commit_o[k] is 1 exactly when retiring slot k is a store.
- R7: On retirement the retirement table entry for the destination register takes the entry's new physical id. When two retiring entries in one cycle write the same register, the younger one wins. rrat_map_o holds register a at bits [a*PR_W +: PR_W].
- R8: A completion with done_mark_i set flags the entry. A flagged entry is the last to retire in its cycle, even if younger entries are ready.
- R9: irq_i flags the oldest entry that is still held after this cycle's retirements. If none remains, the interrupt is ignored.
- R10: In the cycle after a flagged entry retires, flush_o is 1 for one cycle and the queue is empty with both pointers at 0. rrat_map_o then includes the flagged entry's mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocate a new entry this cycle |
| alloc_has_dst_i | input | 1 | Entry writes a register |
| alloc_is_store_i | input | 1 | Entry is a store |
| alloc_areg_i | input | AR_W | Destination architectural register |
| alloc_preg_i | input | PR_W | Newly mapped physical id |
| alloc_prev_i | input | PR_W | Physical id previously mapped to the destination |
| alloc_ready_o | output | 1 | Queue can accept an entry |
| alloc_idx_o | output | IDX_W | Slot the next allocation takes |
| done_valid_i | input | 1 | Completion report |
| done_idx_i | input | IDX_W | Slot that completed |
| done_mark_i | input | 1 | Completion faulted or mispredicted |
| irq_i | input | 1 | Interrupt request |
| commit_cnt_o | output | CNT_W | Entries retiring this cycle |
| free_valid_o | output | W | Per retiring slot: a physical id is freed |
| free_preg_o | output | W*PR_W | Per retiring slot: freed physical id |
| store_commit_o | output | W | Per retiring slot: release a store |
| rrat_map_o | output | AREGS*PR_W | Retirement alias table contents |
| flush_o | output | 1 | Recovery pulse, one cycle |

## Verification
Two things can fall in the same cycle: the interrupt request and the retirement of the head entry. The bench lets the head retire in the very cycle irq_i is raised, while one younger entry waits. The interrupt must land on that younger entry, so when the younger entry retires alone, flush_o must follow and the retirement table must show its mapping. A second overlap puts a completion in the same cycle as the scan that is retiring older entries. The bench then checks that the completed entry retires only on the following cycle, with the expected count and freed id.

// File: rtl/retire_pkg.sv
package retire_pkg;

  typedef struct packed {
    logic valid;
    logic ready;
    logic mark;
    logic has_dst;
    logic is_store;
  } ent_flags_t;

endpackage

// File: rtl/retire_store.sv
module retire_store
  import retire_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AR_W  = 3,
  parameter int unsigned PR_W  = 5,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           flush_i,
  input  logic                           alloc_en_i,
  input  logic [IDX_W-1:0]               alloc_idx_i,
  input  logic                           alloc_has_dst_i,
  input  logic                           alloc_is_store_i,
  input  logic [AR_W-1:0]                alloc_areg_i,
  input  logic [PR_W-1:0]                alloc_preg_i,
  input  logic [PR_W-1:0]                alloc_prev_i,
  input  logic                           done_en_i,
  input  logic [IDX_W-1:0]               done_idx_i,
  input  logic                           done_mark_i,
  input  logic                           irq_en_i,
  input  logic [IDX_W-1:0]               irq_idx_i,
  input  logic [DEPTH-1:0]               retire_mask_i,
  output ent_flags_t [DEPTH-1:0]         flags_o,
  output logic [DEPTH-1:0][AR_W-1:0]     areg_o,
  output logic [DEPTH-1:0][PR_W-1:0]     preg_o,
  output logic [DEPTH-1:0][PR_W-1:0]     prev_o
);

  ent_flags_t [DEPTH-1:0]     flags_q;
  logic [DEPTH-1:0][AR_W-1:0] areg_q;
  logic [DEPTH-1:0][PR_W-1:0] preg_q;
  logic [DEPTH-1:0][PR_W-1:0] prev_q;

  // later writes override earlier ones: retire clear, completion, irq, alloc
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else if (flush_i) begin
      flags_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (retire_mask_i[i]) flags_q[i] <= '0;
      end
      if (done_en_i && flags_q[done_idx_i].valid) begin
        flags_q[done_idx_i].ready <= 1'b1;
        if (done_mark_i) flags_q[done_idx_i].mark <= 1'b1;
      end
      if (irq_en_i) flags_q[irq_idx_i].mark <= 1'b1;
      if (alloc_en_i) begin
        flags_q[alloc_idx_i] <= '{valid: 1'b1, ready: 1'b0, mark: 1'b0,
                                  has_dst: alloc_has_dst_i,
                                  is_store: alloc_is_store_i};
      end
    end
  end

  // payload needs no reset: only read behind a valid flag
  always_ff @(posedge clk_i) begin
    if (alloc_en_i) begin
      areg_q[alloc_idx_i] <= alloc_areg_i;
      preg_q[alloc_idx_i] <= alloc_preg_i;
      prev_q[alloc_idx_i] <= alloc_prev_i;
    end
  end

  assign flags_o = flags_q;
  assign areg_o  = areg_q;
  assign preg_o  = preg_q;
  assign prev_o  = prev_q;

endmodule

// File: rtl/retire_window.sv
module retire_window
  import retire_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 4,
  parameter int unsigned AR_W  = 3,
  parameter int unsigned PR_W  = 5,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic [IDX_W-1:0]           head_idx_i,
  input  ent_flags_t [DEPTH-1:0]     flags_i,
  input  logic [DEPTH-1:0][AR_W-1:0] areg_i,
  input  logic [DEPTH-1:0][PR_W-1:0] preg_i,
  input  logic [DEPTH-1:0][PR_W-1:0] prev_i,
  output logic [CNT_W-1:0]           cnt_o,
  output logic [DEPTH-1:0]           retire_mask_o,
  output logic                       mark_hit_o,
  output logic [W-1:0]               free_valid_o,
  output logic [W-1:0]               store_o,
  output logic [W-1:0][AR_W-1:0]     upd_areg_o,
  output logic [W-1:0][PR_W-1:0]     upd_preg_o,
  output logic [W-1:0][PR_W-1:0]     free_preg_o
);

  logic             go;
  logic             take;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;

  // serial scan: a non-ready or flagged entry closes the window
  always_comb begin
    go            = 1'b1;
    take          = 1'b0;
    idx           = '0;
    cnt           = '0;
    retire_mask_o = '0;
    mark_hit_o    = 1'b0;
    free_valid_o  = '0;
    store_o       = '0;
    upd_areg_o    = '0;
    upd_preg_o    = '0;
    free_preg_o   = '0;
    for (int k = 0; k < W; k++) begin
      idx  = head_idx_i + IDX_W'(k);
      take = go & flags_i[idx].valid & flags_i[idx].ready;
      if (take) begin
        retire_mask_o[idx] = 1'b1;
        cnt                = cnt + 1'b1;
        if (flags_i[idx].mark) begin
          mark_hit_o = 1'b1;
          go         = 1'b0;
        end
      end else begin
        go = 1'b0;
      end
      free_valid_o[k] = take & flags_i[idx].has_dst;
      store_o[k]      = take & flags_i[idx].is_store;
      upd_areg_o[k]   = areg_i[idx];
      upd_preg_o[k]   = preg_i[idx];
      free_preg_o[k]  = prev_i[idx];
    end
    cnt_o = cnt;
  end

endmodule

// File: rtl/retire_rrat.sv
module retire_rrat #(
  parameter int unsigned AREGS = 8,
  parameter int unsigned W     = 4,
  parameter int unsigned AR_W  = 3,
  parameter int unsigned PR_W  = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [W-1:0]               we_i,
  input  logic [W-1:0][AR_W-1:0]     areg_i,
  input  logic [W-1:0][PR_W-1:0]     preg_i,
  output logic [AREGS-1:0][PR_W-1:0] map_o
);

  logic [AREGS-1:0][PR_W-1:0] map_q;

  // ascending slot order: the youngest write to a register lands last
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < AREGS; a++) map_q[a] <= PR_W'(a);
    end else begin
      for (int k = 0; k < W; k++) begin
        if (we_i[k]) map_q[areg_i[k]] <= preg_i[k];
      end
    end
  end

  assign map_o = map_q;

endmodule

// File: rtl/retire_buf.sv
module retire_buf
  import retire_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 4,
  parameter int unsigned AREGS = 8,
  parameter int unsigned PREGS = 32,
  localparam int unsigned AR_W  = $clog2(AREGS),
  localparam int unsigned PR_W  = $clog2(PREGS),
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned PTR_W = IDX_W + 1,
  localparam int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  alloc_valid_i,
  input  logic                  alloc_has_dst_i,
  input  logic                  alloc_is_store_i,
  input  logic [AR_W-1:0]       alloc_areg_i,
  input  logic [PR_W-1:0]       alloc_preg_i,
  input  logic [PR_W-1:0]       alloc_prev_i,
  output logic                  alloc_ready_o,
  output logic [IDX_W-1:0]      alloc_idx_o,
  input  logic                  done_valid_i,
  input  logic [IDX_W-1:0]      done_idx_i,
  input  logic                  done_mark_i,
  input  logic                  irq_i,
  output logic [CNT_W-1:0]      commit_cnt_o,
  output logic [W-1:0]          free_valid_o,
  output logic [W*PR_W-1:0]     free_preg_o,
  output logic [W-1:0]          store_commit_o,
  output logic [AREGS*PR_W-1:0] rrat_map_o,
  output logic                  flush_o
);

  logic [PTR_W-1:0]           head_q, tail_q;
  logic                       flush_q;
  logic                       full, alloc_en, irq_en, flush_req;
  logic [IDX_W-1:0]           head_idx, tail_idx, irq_idx;
  logic [CNT_W-1:0]           cnt;
  logic [DEPTH-1:0]           retire_mask;
  ent_flags_t [DEPTH-1:0]     flags;
  logic [DEPTH-1:0][AR_W-1:0] areg;
  logic [DEPTH-1:0][PR_W-1:0] preg, prev;
  logic [W-1:0]               free_valid, store_rel;
  logic [W-1:0][AR_W-1:0]     upd_areg;
  logic [W-1:0][PR_W-1:0]     upd_preg, free_preg;
  logic [AREGS-1:0][PR_W-1:0] map;

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign full     = (head_q[IDX_W] != tail_q[IDX_W]) && (head_idx == tail_idx);
  assign alloc_en = alloc_valid_i & ~full & ~flush_req;

  // interrupt lands on the first entry surviving this cycle's retirement
  assign irq_idx = head_idx + IDX_W'(cnt);
  assign irq_en  = irq_i & flags[irq_idx].valid & ~retire_mask[irq_idx] & ~flush_req;

  retire_store #(.DEPTH(DEPTH), .AR_W(AR_W), .PR_W(PR_W)) u_store (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .flush_i          (flush_req),
    .alloc_en_i       (alloc_en),
    .alloc_idx_i      (tail_idx),
    .alloc_has_dst_i  (alloc_has_dst_i),
    .alloc_is_store_i (alloc_is_store_i),
    .alloc_areg_i     (alloc_areg_i),
    .alloc_preg_i     (alloc_preg_i),
    .alloc_prev_i     (alloc_prev_i),
    .done_en_i        (done_valid_i),
    .done_idx_i       (done_idx_i),
    .done_mark_i      (done_mark_i),
    .irq_en_i         (irq_en),
    .irq_idx_i        (irq_idx),
    .retire_mask_i    (retire_mask),
    .flags_o          (flags),
    .areg_o           (areg),
    .preg_o           (preg),
    .prev_o           (prev)
  );

  retire_window #(.DEPTH(DEPTH), .W(W), .AR_W(AR_W), .PR_W(PR_W)) u_window (
    .head_idx_i    (head_idx),
    .flags_i       (flags),
    .areg_i        (areg),
    .preg_i        (preg),
    .prev_i        (prev),
    .cnt_o         (cnt),
    .retire_mask_o (retire_mask),
    .mark_hit_o    (flush_req),
    .free_valid_o  (free_valid),
    .store_o       (store_rel),
    .upd_areg_o    (upd_areg),
    .upd_preg_o    (upd_preg),
    .free_preg_o   (free_preg)
  );

  retire_rrat #(.AREGS(AREGS), .W(W), .AR_W(AR_W), .PR_W(PR_W)) u_rrat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (free_valid),
    .areg_i (upd_areg),
    .preg_i (upd_preg),
    .map_o  (map)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= flush_req;
      if (flush_req) begin
        head_q <= '0;
        tail_q <= '0;
      end else begin
        head_q <= head_q + PTR_W'(cnt);
        if (alloc_en) tail_q <= tail_q + 1'b1;
      end
    end
  end

  assign alloc_ready_o  = ~full;
  assign alloc_idx_o    = tail_idx;
  assign commit_cnt_o   = cnt;
  assign free_valid_o   = free_valid;
  assign free_preg_o    = free_preg;
  assign store_commit_o = store_rel;
  assign rrat_map_o     = map;
  assign flush_o        = flush_q;

endmodule

// File: rtl/retire_buf_chk.sv
module retire_buf_chk #(
  parameter int unsigned W     = 4,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             alloc_valid_i,
  input logic             alloc_ready_o,
  input logic [IDX_W-1:0] alloc_idx_o,
  input logic [CNT_W-1:0] commit_cnt_o,
  input logic [W-1:0]     free_valid_o,
  input logic [W-1:0]     store_commit_o,
  input logic             flush_req,
  input logic             flush_o
);

  // R2
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && !alloc_ready_o && !flush_req) |=> $stable(alloc_idx_o));

  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_cnt_o <= CNT_W'(W));

  // R5
  free_in_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(free_valid_o) <= int'(commit_cnt_o));

  // R6
  store_in_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(store_commit_o) <= int'(commit_cnt_o));

  // R10
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (commit_cnt_o == '0 && alloc_ready_o && alloc_idx_o == '0));

  // R10
  flush_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);

endmodule

bind retire_buf retire_buf_chk #(.W(W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .alloc_valid_i  (alloc_valid_i),
  .alloc_ready_o  (alloc_ready_o),
  .alloc_idx_o    (alloc_idx_o),
  .commit_cnt_o   (commit_cnt_o),
  .free_valid_o   (free_valid_o),
  .store_commit_o (store_commit_o),
  .flush_req      (flush_req),
  .flush_o        (flush_o)
);

// File: tb/retire_buf_bench.sv
module retire_buf_bench;
  localparam int PR_W = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid, alloc_has_dst, alloc_is_store;
  logic [2:0]  alloc_areg;
  logic [4:0]  alloc_preg, alloc_prev;
  logic        alloc_ready;
  logic [2:0]  alloc_idx;
  logic        done_valid, done_mark, irq;
  logic [2:0]  done_idx;
  logic [2:0]  commit_cnt;
  logic [3:0]  free_valid, store_commit;
  logic [19:0] free_preg;
  logic [39:0] rrat_map;
  logic        flush;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  retire_buf u_retire_buf (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_has_dst_i(alloc_has_dst),
    .alloc_is_store_i(alloc_is_store), .alloc_areg_i(alloc_areg),
    .alloc_preg_i(alloc_preg), .alloc_prev_i(alloc_prev),
    .alloc_ready_o(alloc_ready), .alloc_idx_o(alloc_idx),
    .done_valid_i(done_valid), .done_idx_i(done_idx), .done_mark_i(done_mark),
    .irq_i(irq), .commit_cnt_o(commit_cnt), .free_valid_o(free_valid),
    .free_preg_o(free_preg), .store_commit_o(store_commit),
    .rrat_map_o(rrat_map), .flush_o(flush)
  );

  // {alloc, areg[3], preg[5], prev[5], done, idx[3], exp_cnt[3], exp_free0[5]}
  localparam logic [25:0] VEC [8] = '{
    {1'b1, 3'd1, 5'd9,  5'd1, 1'b0, 3'd0, 3'd0, 5'd0},
    {1'b1, 3'd2, 5'd10, 5'd2, 1'b1, 3'd0, 3'd0, 5'd0},
    {1'b1, 3'd3, 5'd11, 5'd3, 1'b0, 3'd0, 3'd1, 5'd1},
    {1'b1, 3'd4, 5'd12, 5'd4, 1'b1, 3'd2, 3'd0, 5'd0},
    {1'b0, 3'd0, 5'd0,  5'd0, 1'b1, 3'd1, 3'd0, 5'd0},
    {1'b0, 3'd0, 5'd0,  5'd0, 1'b1, 3'd3, 3'd2, 5'd2},
    {1'b0, 3'd0, 5'd0,  5'd0, 1'b0, 3'd0, 3'd1, 5'd4},
    {1'b0, 3'd0, 5'd0,  5'd0, 1'b0, 3'd0, 3'd0, 5'd0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] map_of(input int a);
    return rrat_map[a*PR_W +: PR_W];
  endfunction

  function automatic logic [4:0] fp(input int k);
    return free_preg[k*PR_W +: PR_W];
  endfunction

  task automatic idle();
    alloc_valid = 0; alloc_has_dst = 0; alloc_is_store = 0;
    alloc_areg = 0; alloc_preg = 0; alloc_prev = 0;
    done_valid = 0; done_idx = 0; done_mark = 0; irq = 0;
  endtask

  task automatic nxt();
    @(negedge clk);
    idle();
  endtask

  task automatic put(input logic hd, input logic st, input int ar, input int pr, input int pv);
    nxt();
    alloc_valid = 1; alloc_has_dst = hd; alloc_is_store = st;
    alloc_areg = 3'(ar); alloc_preg = 5'(pr); alloc_prev = 5'(pv);
  endtask

  task automatic fin(input int idx, input logic mk);
    nxt();
    done_valid = 1; done_idx = 3'(idx); done_mark = mk;
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    nxt(); #1;
    chk("R1 ready", alloc_ready, 1);
    chk("R1 idx", alloc_idx, 0);
    chk("R1 cnt", commit_cnt, 0);
    chk("R1 flush", flush, 0);
    chk("R1 map3", map_of(3), 3);
    chk("R1 map7", map_of(7), 7);

    // table: in-order allocation, out-of-order completion (R3, R4, R5)
    for (int s = 0; s < 8; s++) begin
      if (s > 0) nxt();
      alloc_valid   = VEC[s][25];
      alloc_has_dst = 1'b1;
      alloc_areg    = VEC[s][24:22];
      alloc_preg    = VEC[s][21:17];
      alloc_prev    = VEC[s][16:12];
      done_valid    = VEC[s][11];
      done_idx      = VEC[s][10:8];
      #1;
      chk($sformatf("R4 step%0d cnt", s), commit_cnt, VEC[s][7:5]);
      if (VEC[s][7:5] != 0) chk($sformatf("R5 step%0d free0", s), fp(0), VEC[s][4:0]);
    end
    chk("R7 map1", map_of(1), 9);
    chk("R7 map4", map_of(4), 12);
    chk("R2 wrap idx", alloc_idx, 4);

    // W limit, store release, no-destination entry, same register twice
    put(1, 0, 5, 13, 5);
    put(0, 1, 0, 0, 0);
    put(0, 0, 0, 0, 0);
    put(1, 0, 5, 16, 13);
    put(1, 0, 6, 17, 6);
    put(1, 0, 7, 18, 7);
    fin(1, 0); fin(0, 0); fin(7, 0); fin(6, 0); fin(5, 0); fin(4, 0);
    nxt(); #1;
    chk("R4 window cnt", commit_cnt, 4);
    chk("R5 free mask", free_valid, 4'b1001);
    chk("R6 store mask", store_commit, 4'b0010);
    chk("R5 free slot0", fp(0), 5);
    chk("R5 free slot3", fp(3), 13);
    nxt(); #1;
    chk("R4 rest cnt", commit_cnt, 2);
    chk("R5 rest mask", free_valid, 4'b0011);
    chk("R5 rest slot1", fp(1), 7);
    nxt(); #1;
    chk("R7 younger wins", map_of(5), 16);
    chk("R7 map6", map_of(6), 17);

    // full queue, flagged completion, flush
    for (int k = 0; k < 8; k++) put(1, 0, 1, 20 + k, 1);
    nxt(); #1;
    chk("R2 full ready", alloc_ready, 0);
    chk("R2 full idx", alloc_idx, 2);
    alloc_valid = 1; alloc_has_dst = 1; alloc_areg = 2; alloc_preg = 31;
    nxt(); #1;
    chk("R2 ignored idx", alloc_idx, 2);
    chk("R2 ignored ready", alloc_ready, 0);
    done_valid = 1; done_idx = 4;
    fin(3, 1);
    fin(2, 0);
    nxt(); #1;
    chk("R8 stop at mark", commit_cnt, 2);
    nxt(); #1;
    chk("R10 flush", flush, 1);
    chk("R10 idx", alloc_idx, 0);
    chk("R10 ready", alloc_ready, 1);
    chk("R10 map1", map_of(1), 21);
    chk("R10 map2 kept", map_of(2), 10);
    nxt(); #1;
    chk("R10 pulse", flush, 0);

    // R9 irq while empty is ignored
    irq = 1;
    put(1, 0, 2, 24, 10);
    put(1, 0, 3, 25, 11);
    fin(1, 0); fin(0, 0);
    nxt(); #1;
    chk("R9 empty irq cnt", commit_cnt, 2);
    nxt(); #1;
    chk("R9 empty irq flush", flush, 0);

    // R9 irq in the cycle the head retires lands on the next entry
    put(1, 0, 4, 26, 12);
    put(1, 0, 4, 27, 26);
    fin(2, 0);
    nxt(); #1;
    chk("R4 head cnt", commit_cnt, 1);
    chk("R5 head free", fp(0), 12);
    irq = 1;
    fin(3, 0);
    nxt(); #1;
    chk("R9 survivor cnt", commit_cnt, 1);
    chk("R9 survivor free", fp(0), 26);
    nxt(); #1;
    chk("R9 flush", flush, 1);
    chk("R10 map4", map_of(4), 27);
    chk("R7 map2", map_of(2), 24);

    // R3 completion to an empty slot is ignored
    fin(0, 0);
    put(1, 0, 5, 28, 16);
    nxt(); #1;
    nxt(); #1;
    chk("R3 stale done", commit_cnt, 0);
    done_valid = 1; done_idx = 0;
    nxt(); #1;
    chk("R3 done cnt", commit_cnt, 1);
    nxt(); #1;
    chk("R7 map5", map_of(5), 28);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule